// File: doc/BRIEF.md
# Flash Page Buffer Command Sequencer

This block is the command front end of a flash memory that stages program data in a 256-byte page buffer. It watches bus write cycles, each an address, a data byte and a write enable, and decodes them into a multi-cycle command protocol. Three-cycle framings open and close a buffer load session. A burst command deposits 256 bytes into the buffer, each selected by the low address byte. A two-cycle program command then passes the buffer to the programming engine through a request/acknowledge handshake. When the engine finishes, the whole buffer reads back as all ones again.

The programming engine reads the staged bytes through a read port (`rd_idx`/`rd_data`). The same port lets any observer see the buffer. While the engine reports a suspend, the buffer is treated as invalid and every read returns 0xFF.

Each byte has a valid bit. A clear makes every byte read as 0xFF in one cycle, and no multi-cycle sweep is needed, either at power-up or after a program.

Top module: `pgbuf_cmd_seq`

## Requirements
- R1: After reset the sequencer is idle, `busy`, `prog_req`, `sess_open` and `seq_err` are low, and every buffer byte reads 0xFF.
- R2: The sequence 0xDB, 0xFF, 0x00 starts a burst of exactly 256 write cycles. Each burst cycle stores its data byte at buffer index `wr_addr[7:0]`, and `wr_addr[20:8]` has no effect. After the 256th cycle the session stays open (`sess_open`=1) and the next write is decoded as a command again.
- R3: The sequence 0xDB, a, b, where (a,b) is not (0xFF,0x00) and not a reserved pair, opens a session (`sess_open`=1) without loading data. A burst inside an open session may hit the same index many times. The last value written to an index wins, and indices the burst does not hit keep their earlier contents.
- R4: After a first byte of 0xDB or 0x5F, the reserved pairs (0x20,0xD0) and (0x77,0xD0) abort the command. The sequencer returns to idle with the session closed and sets `seq_err`=1. Buffer contents are kept.
- R5: The sequence 0x5F, a, b (not a reserved pair) closes the session (`sess_open`=0). Buffer contents persist after the close.
- R6: In idle, 0x0E followed by 0xD0 raises `busy` and `prog_req` together from the cycle after the confirm. `prog_page` then carries `wr_addr[20:8]` of the confirm cycle.
- R7: While `busy` is high, every write cycle is ignored. Buffer contents, `sess_open` and `prog_page` are unchanged.
- R8: A cycle with `prog_ack` high while busy drops `busy` and `prog_req` on the next cycle, and from then on every buffer byte reads 0xFF.
- R9: A write that does not fit the expected byte aborts the sequence to idle and sets `seq_err`=1. This covers an unknown first byte in idle, any first byte other than 0xDB or 0x5F in an open session, and a second byte other than 0xD0 after 0x0E or 0x9C. The next command that completes successfully clears `seq_err`.
- R10: In idle, 0x9C followed by 0xD0 clears the buffer so that every byte reads 0xFF.
- R11: While `suspend` is high, `rd_data` reads 0xFF for every index. When `suspend` goes low, the stored contents read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Bus write strobe, one write per cycle while high |
| wr_addr | input | ADDR_W (21) | Bus write address |
| wr_data | input | 8 | Bus write data: a command byte or a buffer byte |
| prog_ack | input | 1 | Engine acknowledge that ends programming |
| suspend | input | 1 | Engine suspend indication; the buffer reads invalid while high |
| rd_idx | input | IDX_W (8) | Buffer read index |
| rd_data | output | 8 | Buffer byte at `rd_idx` (0xFF if unwritten, cleared or suspended) |
| prog_req | output | 1 | Request to the engine to program the buffer |
| prog_page | output | ADDR_W-IDX_W (13) | Target page captured at the confirm cycle |
| busy | output | 1 | High from confirm until acknowledge; writes are ignored |
| sess_open | output | 1 | A buffer load session is open |
| seq_err | output | 1 | The last aborted sequence has not yet been followed by a successful command |

## Verification
The bench builds the block with its default parameters: a 21-bit address and a 256-byte page, so an 8-bit index and a 13-bit page field. At this size every burst is a full 256-cycle load whose upper address bits change on each write, and a page number that uses the topmost address bit can be captured and held through a busy period. The scoreboard queues expected buffer bytes from an independent model of the buffer. It compares them through the read port after each phase: burst loads, repeated-index bursts, reserved-pair aborts, clear, suspend, writes ignored while busy, and the refill to all ones after the acknowledge.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPEN,
    ST_LD1,
    ST_LD2,
    ST_END1,
    ST_END2,
    ST_PRG,
    ST_CLR,
    ST_BURST,
    ST_WAIT
  } seq_st_e;

  localparam logic [BYTE_W-1:0] OP_LOAD    = 8'hDB;
  localparam logic [BYTE_W-1:0] OP_END     = 8'h5F;
  localparam logic [BYTE_W-1:0] OP_PROG    = 8'h0E;
  localparam logic [BYTE_W-1:0] OP_CLEAR   = 8'h9C;
  localparam logic [BYTE_W-1:0] OP_CONFIRM = 8'hD0;
  localparam logic [BYTE_W-1:0] OP_BURST_A = 8'hFF;
  localparam logic [BYTE_W-1:0] OP_BURST_B = 8'h00;
  localparam logic [BYTE_W-1:0] OP_ERASE   = 8'h20;
  localparam logic [BYTE_W-1:0] OP_LOCK    = 8'h77;

  // Pairs that belong to erase or lock-bit commands and may not follow a frame byte
  function automatic logic is_reserved(input logic [BYTE_W-1:0] a,
                                       input logic [BYTE_W-1:0] b);
    return (b == OP_CONFIRM) && ((a == OP_ERASE) || (a == OP_LOCK));
  endfunction

endpackage

// File: rtl/pgbuf_store.sv
module pgbuf_store
  import pgbuf_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int IDX_W      = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [BYTE_W-1:0] w_data,
  input  logic              clr_all,
  input  logic [IDX_W-1:0]  r_idx,
  input  logic              hide,
  output logic [BYTE_W-1:0] r_data
);

  logic [BYTE_W-1:0]     mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;
  logic [PAGE_BYTES-1:0] vld_d;

  // Data array: no reset, validity is tracked separately
  always_ff @(posedge clk) begin
    if (we) begin
      mem[w_idx] <= w_data;
    end
  end

  always_comb begin
    vld_d = vld_q;
    if (clr_all) begin
      vld_d = '0;
    end else if (we) begin
      vld_d[w_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (clr_all || we) begin
      vld_q <= vld_d;
    end
  end

  always_comb begin
    if (hide || !vld_q[r_idx]) begin
      r_data = '1;
    end else begin
      r_data = mem[r_idx];
    end
  end

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (vld_q == '0)) else $error("clear left valid bytes"); // R10

  AST_WRITE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr_all) |=> vld_q[$past(w_idx)]) else $error("written byte not valid"); // R2

endmodule

// File: rtl/pgbuf_fsm.sv
module pgbuf_fsm
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int PAGE_BYTES = 256,
  parameter int IDX_W      = $clog2(PAGE_BYTES),
  parameter int PAGE_W     = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              prog_ack,
  output logic              st_we,
  output logic [IDX_W-1:0]  st_idx,
  output logic [BYTE_W-1:0] st_data,
  output logic              st_clr,
  output logic              prog_req,
  output logic [PAGE_W-1:0] prog_page,
  output logic              busy,
  output logic              sess_open,
  output logic              seq_err
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_BYTES - 1);

  seq_st_e           st_q, st_d;
  logic [BYTE_W-1:0] arg_q, arg_d;
  logic [IDX_W-1:0]  cnt_q, cnt_d;
  logic              err_q, err_d;
  logic              req_q, req_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              arg_en, cnt_en, page_en;
  logic              err_set, ok_done;

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    arg_d   = arg_q;
    cnt_d   = cnt_q;
    req_d   = req_q;
    page_d  = page_q;
    arg_en  = 1'b0;
    cnt_en  = 1'b0;
    page_en = 1'b0;
    err_set = 1'b0;
    ok_done = 1'b0;
    st_we   = 1'b0;
    st_clr  = 1'b0;
    st_idx  = wr_addr[IDX_W-1:0];
    st_data = wr_data;

    if (st_q == ST_WAIT) begin
      if (prog_ack) begin
        st_clr = 1'b1;
        req_d  = 1'b0;
        st_d   = ST_IDLE;
      end
    end else if (wr_en) begin
      case (st_q)
        ST_IDLE: begin
          if (wr_data == OP_LOAD) begin
            st_d = ST_LD1;
          end else if (wr_data == OP_END) begin
            st_d = ST_END1;
          end else if (wr_data == OP_PROG) begin
            st_d = ST_PRG;
          end else if (wr_data == OP_CLEAR) begin
            st_d = ST_CLR;
          end else begin
            err_set = 1'b1;
          end
        end
        ST_OPEN: begin
          if (wr_data == OP_LOAD) begin
            st_d = ST_LD1;
          end else if (wr_data == OP_END) begin
            st_d = ST_END1;
          end else begin
            err_set = 1'b1;
          end
        end
        ST_LD1: begin
          arg_en = 1'b1;
          arg_d  = wr_data;
          st_d   = ST_LD2;
        end
        ST_LD2: begin
          if (is_reserved(arg_q, wr_data)) begin
            err_set = 1'b1;
          end else if ((arg_q == OP_BURST_A) && (wr_data == OP_BURST_B)) begin
            ok_done = 1'b1;
            cnt_en  = 1'b1;
            cnt_d   = '0;
            st_d    = ST_BURST;
          end else begin
            ok_done = 1'b1;
            st_d    = ST_OPEN;
          end
        end
        ST_END1: begin
          arg_en = 1'b1;
          arg_d  = wr_data;
          st_d   = ST_END2;
        end
        ST_END2: begin
          if (is_reserved(arg_q, wr_data)) begin
            err_set = 1'b1;
          end else begin
            ok_done = 1'b1;
            st_d    = ST_IDLE;
          end
        end
        ST_PRG: begin
          if (wr_data == OP_CONFIRM) begin
            ok_done = 1'b1;
            req_d   = 1'b1;
            page_en = 1'b1;
            page_d  = wr_addr[ADDR_W-1:IDX_W];
            st_d    = ST_WAIT;
          end else begin
            err_set = 1'b1;
          end
        end
        ST_CLR: begin
          if (wr_data == OP_CONFIRM) begin
            ok_done = 1'b1;
            st_clr  = 1'b1;
            st_d    = ST_IDLE;
          end else begin
            err_set = 1'b1;
          end
        end
        ST_BURST: begin
          st_we  = 1'b1;
          cnt_en = 1'b1;
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == LAST_IDX) begin
            st_d = ST_OPEN;
          end
        end
        default: begin
          st_d = ST_IDLE;
        end
      endcase
    end

    err_d = err_q;
    if (err_set) begin
      st_d  = ST_IDLE;
      err_d = 1'b1;
    end else if (ok_done) begin
      err_d = 1'b0;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
      req_q <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arg_q <= '0;
    end else if (arg_en) begin
      arg_q <= arg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (page_en) begin
      page_q <= page_d;
    end
  end

  assign prog_req  = req_q;
  assign prog_page = page_q;
  assign busy      = (st_q == ST_WAIT);
  assign sess_open = (st_q == ST_OPEN) || (st_q == ST_BURST);
  assign seq_err   = err_q;

  AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> ((st_q == ST_IDLE) && seq_err)) else $error("abort did not reach idle"); // R4

  AST_REQ_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req == busy) else $error("request and busy disagree"); // R6

  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_ack) |=> (busy && $stable(prog_page))) else $error("busy state disturbed"); // R7

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && prog_ack) |=> (!busy && !prog_req)) else $error("ack did not release"); // R8

  AST_BURST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_BURST) && wr_en && (cnt_q == LAST_IDX)) |=> (st_q == ST_OPEN))
    else $error("burst did not end after last byte"); // R2

  AST_NO_STORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !st_we) else $error("store write while busy"); // R7

endmodule

// File: rtl/pgbuf_cmd_seq.sv
module pgbuf_cmd_seq
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int PAGE_BYTES = 256,
  parameter int IDX_W      = $clog2(PAGE_BYTES),
  parameter int PAGE_W     = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              prog_ack,
  input  logic              suspend,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_data,
  output logic              prog_req,
  output logic [PAGE_W-1:0] prog_page,
  output logic              busy,
  output logic              sess_open,
  output logic              seq_err
);

  logic [1:0]        rst_sync_q;
  logic              rst_ns;
  logic              st_we;
  logic              st_clr;
  logic [IDX_W-1:0]  st_idx;
  logic [BYTE_W-1:0] st_data;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_ns = rst_sync_q[1];

  pgbuf_fsm #(
    .ADDR_W    (ADDR_W),
    .PAGE_BYTES(PAGE_BYTES),
    .IDX_W     (IDX_W),
    .PAGE_W    (PAGE_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_ns),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .prog_ack (prog_ack),
    .st_we    (st_we),
    .st_idx   (st_idx),
    .st_data  (st_data),
    .st_clr   (st_clr),
    .prog_req (prog_req),
    .prog_page(prog_page),
    .busy     (busy),
    .sess_open(sess_open),
    .seq_err  (seq_err)
  );

  pgbuf_store #(
    .PAGE_BYTES(PAGE_BYTES),
    .IDX_W     (IDX_W)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_ns),
    .we     (st_we),
    .w_idx  (st_idx),
    .w_data (st_data),
    .clr_all(st_clr),
    .r_idx  (rd_idx),
    .hide   (suspend),
    .r_data (rd_data)
  );

endmodule

// File: tb/tb_pgbuf_cmd_seq.sv
module tb_pgbuf_cmd_seq;

  localparam int ADDR_W = 21;
  localparam int NB     = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [20:0] wr_addr;
  logic [7:0]  wr_data;
  logic        prog_ack;
  logic        suspend;
  logic [7:0]  rd_idx;
  logic [7:0]  rd_data;
  logic        prog_req;
  logic [12:0] prog_page;
  logic        busy;
  logic        sess_open;
  logic        seq_err;

  always #2.5 clk = ~clk;

  pgbuf_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_ack(prog_ack), .suspend(suspend), .rd_idx(rd_idx), .rd_data(rd_data),
    .prog_req(prog_req), .prog_page(prog_page), .busy(busy), .sess_open(sess_open),
    .seq_err(seq_err)
  );

  typedef struct {
    int    idx;
    int    exp;
    string tag;
  } item_t;

  item_t      sbq[$];
  logic [7:0] model [NB];
  int         checks = 0;
  int         errors = 0;
  bit         done   = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver side: queue an expected buffer byte from the model
  task automatic expect_byte(input int idx, input string tag);
    item_t it;
    it.idx = idx;
    it.exp = int'(model[idx]);
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(posedge clk);
    @(posedge clk);
  endtask

  // Monitor: pops expected items and compares the read port
  initial begin
    item_t it;
    rd_idx = '0;
    forever begin
      @(negedge clk);
      if (sbq.size() != 0) begin
        it = sbq.pop_front();
        rd_idx = 8'(it.idx);
        #1;
        chk(it.tag, int'(rd_data), it.exp);
      end
    end
  end

  task automatic wr(input logic [20:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic cmd3(input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    wr(21'h0, d0);
    wr(21'h0, d1);
    wr(21'h0, d2);
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic model_ff();
    for (int i = 0; i < NB; i++) model[i] = 8'hFF;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    prog_ack = 1'b0; suspend = 1'b0;
    model_ff();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    settle();
    chk("R1 busy", busy, 0);
    chk("R1 prog_req", prog_req, 0);
    chk("R1 sess_open", sess_open, 0);
    chk("R1 seq_err", seq_err, 0);
    expect_byte(0, "R1 byte0"); expect_byte(5, "R1 byte5"); expect_byte(255, "R1 byte255");
    drain();

    // R2 burst from idle, upper address bits vary
    cmd3(8'hDB, 8'hFF, 8'h00);
    for (int i = 0; i < NB; i++) begin
      wr({13'(i * 37 + 5), 8'(i)}, 8'(i) ^ 8'h5A);
      model[i] = 8'(i) ^ 8'h5A;
    end
    settle();
    chk("R2 session after burst", sess_open, 1);
    // R2/R5 next write is a command (close), address 0x12 must not be overwritten
    wr(21'h12, 8'h5F); wr(21'h12, 8'h01); wr(21'h12, 8'h02);
    settle();
    chk("R5 closed", sess_open, 0);
    chk("R5 seq_err", seq_err, 0);
    expect_byte(8'h12, "R2 post-burst write not stored");
    expect_byte(0, "R2 byte0"); expect_byte(100, "R2 byte100"); expect_byte(255, "R5 persists");
    drain();

    // R3 plain session, then burst hitting only two indices
    cmd3(8'hDB, 8'h11, 8'h22);
    settle();
    chk("R3 session open", sess_open, 1);
    cmd3(8'hDB, 8'hFF, 8'h00);
    for (int i = 0; i < NB; i++) begin
      if (i % 2 == 1) wr(21'h1F_0007, 8'hB0 + 8'(i));
      else            wr(21'h00_0003, 8'hA0 + 8'(i));
    end
    model[3] = 8'hA0 + 8'd254;
    model[7] = 8'hB0 + 8'd255;
    cmd3(8'h5F, 8'h00, 8'h00);
    expect_byte(3, "R3 last write wins idx3"); expect_byte(7, "R3 last write wins idx7");
    expect_byte(4, "R3 untouched idx4");
    drain();

    // R4 reserved pairs
    cmd3(8'hDB, 8'h20, 8'hD0);
    settle();
    chk("R4 erase pair err", seq_err, 1);
    chk("R4 erase pair closed", sess_open, 0);
    cmd3(8'hDB, 8'h01, 8'h02);
    settle();
    chk("R9 err cleared by good start", seq_err, 0);
    cmd3(8'h5F, 8'h77, 8'hD0);
    settle();
    chk("R4 lock pair err", seq_err, 1);
    chk("R4 lock pair idle", sess_open, 0);
    expect_byte(3, "R4 buffer kept");
    drain();

    // R9 mismatches
    cmd3(8'h5F, 8'h00, 8'h00);
    settle();
    chk("R9 cleared", seq_err, 0);
    wr(21'h0, 8'h0E); wr(21'h0, 8'h55);
    settle();
    chk("R9 bad confirm", seq_err, 1);
    chk("R9 no busy", busy, 0);
    cmd3(8'h5F, 8'h00, 8'h00);
    wr(21'h0, 8'h42);
    settle();
    chk("R9 unknown in idle", seq_err, 1);
    cmd3(8'hDB, 8'h01, 8'h02);
    wr(21'h0, 8'h0E);
    settle();
    chk("R9 program in session", seq_err, 1);
    chk("R9 session aborted", sess_open, 0);
    wr(21'h0, 8'h9C); wr(21'h0, 8'h33);
    settle();
    chk("R9 bad clear confirm", seq_err, 1);
    expect_byte(7, "R9 buffer kept");
    drain();

    // R10 clear
    wr(21'h0, 8'h9C); wr(21'h0, 8'hD0);
    model_ff();
    settle();
    chk("R10 err cleared", seq_err, 0);
    expect_byte(3, "R10 idx3"); expect_byte(7, "R10 idx7"); expect_byte(200, "R10 idx200");
    drain();

    // reload for suspend and program
    cmd3(8'hDB, 8'hFF, 8'h00);
    for (int i = 0; i < NB; i++) begin
      wr({13'h1FFF, 8'(i)}, ~8'(i));
      model[i] = ~8'(i);
    end
    cmd3(8'h5F, 8'h00, 8'h00);

    // R11 suspend
    suspend = 1'b1;
    begin
      item_t it;
      it.idx = 10; it.exp = 8'hFF; it.tag = "R11 hidden"; sbq.push_back(it);
    end
    drain();
    suspend = 1'b0;
    expect_byte(10, "R11 restored");
    drain();

    // R6 program
    wr(21'h0, 8'h0E);
    wr({13'h1ABC, 8'h00}, 8'hD0);
    settle();
    chk("R6 busy", busy, 1);
    chk("R6 prog_req", prog_req, 1);
    chk("R6 page", prog_page, 13'h1ABC);

    // R7 writes ignored while busy
    cmd3(8'hDB, 8'hFF, 8'h00);
    wr(21'h3, 8'h00);
    wr(21'h0, 8'h9C); wr(21'h0, 8'hD0);
    wr(21'h0, 8'h0E); wr({13'h0001, 8'h00}, 8'hD0);
    settle();
    chk("R7 still busy", busy, 1);
    chk("R7 no session", sess_open, 0);
    chk("R7 page held", prog_page, 13'h1ABC);
    expect_byte(3, "R7 idx3 kept"); expect_byte(0, "R7 idx0 kept"); expect_byte(250, "R7 idx250 kept");
    drain();

    // R8 acknowledge
    @(negedge clk);
    prog_ack = 1'b1;
    @(posedge clk);
    #1 prog_ack = 1'b0;
    settle();
    chk("R8 busy low", busy, 0);
    chk("R8 req low", prog_req, 0);
    model_ff();
    expect_byte(0, "R8 refill idx0"); expect_byte(100, "R8 refill idx100");
    expect_byte(255, "R8 refill idx255");
    drain();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule